// File: doc/BRIEF.md
# Modem Status Change Detector

This block watches four active-low handshake inputs from a serial line (clear-to-send, data-set-ready, ring and carrier detect) and keeps an 8-bit status word for a UART register file. The upper nibble shows the present asserted state of each line, which is the complement of its pin. The lower nibble holds sticky change flags. The block raises an interrupt request while any change flag is set.

Reading the status word through the read strobe returns the word and clears all four change flags together. A change that lands in the same cycle as the read is not lost.

In loopback mode the external pins are ignored. Four modem-control output bits then take their place, so software can cause status changes and interrupts by writing its control register. Each external pin passes through a reset-to-idle synchroniser before any edge is detected.

Top module: `modem_status_detect`

## Requirements
- R1: The status word is laid out from bit 7 down to bit 0 as: carrier level, ring level, set-ready level, clear-to-send level, carrier change, ring trailing edge, set-ready change, clear-to-send change.
- R2: With loopback off, each upper-nibble bit equals the complement of its pin. A pin change reaches the status word on the third rising clock edge after it is presented (two synchroniser flops, then the level register).
- R3: The carrier, set-ready and clear-to-send change flags (bits 3, 1, 0) are set when their asserted level changes in either direction.
- R4: The ring flag (bit 2) is set only when the ring pin goes from low to high, which is the asserted level falling. A high-to-low pin transition leaves the flag clear.
- R5: While the read strobe is high, rd_data shows the word as it stands before the read. On the next edge all four change flags clear. Without a read, a set flag stays set.
- R6: A change event detected on the same edge as a read leaves its flag set after that read.
- R7: irq is high exactly when at least one change flag is set.
- R8: With loopback on, the asserted levels take the values of lb_ctl one edge later, with this mapping: clear-to-send from bit 1, set-ready from bit 0, ring from bit 2, carrier from bit 3. A level change made this way sets the flags under the rules of R3 and R4.
- R9: With loopback on, changes on the four external pins have no effect on the status word or on irq.
- R10: After reset the status word is 0x00 and irq is low. The synchronisers reset to the idle (high) pin level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cts_pin_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_pin_n | input | 1 | Data-set-ready pin, active low, asynchronous |
| ri_pin_n | input | 1 | Ring pin, active low, asynchronous |
| dcd_pin_n | input | 1 | Carrier-detect pin, active low, asynchronous |
| lb_ctl | input | 4 | Modem-control bits: 0 terminal-ready, 1 request-to-send, 2 aux out 1, 3 aux out 2 |
| lb_en | input | 1 | Loopback enable |
| rd_strobe | input | 1 | Status read, one cycle per read |
| rd_data | output | 8 | Status word (layout in R1) |
| irq | output | 1 | Modem-status interrupt request |

## Verification
Directed pin steps on single lines separate the two ring edges from each other, and the ring edges from the either-direction lines. Reads placed one edge before a change, and exactly on it, tell a cleared flag from a retained one. Loopback phases drive each control bit alone and wiggle the external pins, which shows the mapping and proves the pins are isolated. A long random run mixes pin toggles, reads and loopback switches against a cycle-accurate bench model, which exposes latency slips and wrong edge polarity.

// File: rtl/msd_pkg.sv
package msd_pkg;

    localparam int LINES = 4;

    // Line index within a level or flag vector; matches the status nibble order
    typedef enum int {
        LN_CTS = 0,
        LN_DSR = 1,
        LN_RI  = 2,
        LN_DCD = 3
    } line_e;

    // Control-bit index within the loopback control vector
    localparam int CTL_DTR  = 0;
    localparam int CTL_RTS  = 1;
    localparam int CTL_OUT1 = 2;
    localparam int CTL_OUT2 = 3;

    typedef logic [LINES-1:0] lvec_t;

    typedef struct packed {
        lvec_t level;   // bits 7..4
        lvec_t delta;   // bits 3..0
    } status_t;

    // Control outputs routed onto the asserted input levels in loopback
    function automatic lvec_t loop_map(input logic [3:0] ctl);
        lvec_t r;
        r[LN_CTS] = ctl[CTL_RTS];
        r[LN_DSR] = ctl[CTL_DTR];
        r[LN_RI]  = ctl[CTL_OUT1];
        r[LN_DCD] = ctl[CTL_OUT2];
        return r;
    endfunction

    // Edge events on asserted levels: any change, except ring which only
    // reports the asserted level dropping (pin rising)
    function automatic lvec_t change_events(input lvec_t prev, input lvec_t cur);
        lvec_t e;
        e         = prev ^ cur;
        e[LN_RI]  = prev[LN_RI] & ~cur[LN_RI];
        return e;
    endfunction

endpackage

// File: rtl/msd_sync.sv
module msd_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= {WIDTH{RST_VAL}};
                    else     stage_q[s] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= {WIDTH{RST_VAL}};
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/msd_source_sel.sv
module msd_source_sel
    import msd_pkg::*;
(
    input  lvec_t      pin_sync_n,
    input  logic [3:0] ctl,
    input  logic       lb_en,
    output lvec_t      asserted
);
    always_comb begin
        if (lb_en) asserted = loop_map(ctl);
        else       asserted = ~pin_sync_n;
    end
endmodule

// File: rtl/msd_tracker.sv
module msd_tracker
    import msd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  lvec_t   asserted_i,
    input  logic    rd_i,
    output status_t status_o,
    output lvec_t   evt_o
);
    lvec_t lvl_q;
    lvec_t flg_q;
    lvec_t flg_kept;

    assign evt_o    = change_events(lvl_q, asserted_i);
    assign flg_kept = rd_i ? '0 : flg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= '0;
            flg_q <= '0;
        end else begin
            lvl_q <= asserted_i;
            flg_q <= flg_kept | evt_o;
        end
    end

    assign status_o.level = lvl_q;
    assign status_o.delta = flg_q;
endmodule

// File: rtl/modem_status_detect.sv
module modem_status_detect
    import msd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cts_pin_n,
    input  logic       dsr_pin_n,
    input  logic       ri_pin_n,
    input  logic       dcd_pin_n,
    input  logic [3:0] lb_ctl,
    input  logic       lb_en,
    input  logic       rd_strobe,
    output logic [7:0] rd_data,
    output logic       irq
);
    lvec_t   pin_raw_n;
    lvec_t   pin_sync_n;
    lvec_t   asserted;
    lvec_t   evt_vec;
    status_t status;

    always_comb begin
        pin_raw_n         = '1;
        pin_raw_n[LN_CTS] = cts_pin_n;
        pin_raw_n[LN_DSR] = dsr_pin_n;
        pin_raw_n[LN_RI]  = ri_pin_n;
        pin_raw_n[LN_DCD] = dcd_pin_n;
    end

    msd_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (pin_raw_n),
        .q_o (pin_sync_n)
    );

    msd_source_sel u_sel (
        .pin_sync_n (pin_sync_n),
        .ctl        (lb_ctl),
        .lb_en      (lb_en),
        .asserted   (asserted)
    );

    msd_tracker u_trk (
        .clk        (clk),
        .rst        (rst),
        .asserted_i (asserted),
        .rd_i       (rd_strobe),
        .status_o   (status),
        .evt_o      (evt_vec)
    );

    assign rd_data = status;
    assign irq     = |status.delta;
endmodule

// File: rtl/modem_status_detect_chk.sv
module modem_status_detect_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] lb_ctl,
    input logic       lb_en,
    input logic       rd_strobe,
    input logic [7:0] rd_data,
    input logic       irq,
    input logic [3:0] evt_vec
);
    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (rd_data == 8'h00 && !irq));

    assert_irq_from_flags_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_data[3:0] != 4'h0) |-> irq);

    assert_read_keeps_new_events_R6: assert property (@(posedge clk) disable iff (rst)
        rd_strobe |=> (rd_data[3:0] == $past(evt_vec)));

    assert_flags_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        !rd_strobe |=> ((rd_data[3:0] & $past(rd_data[3:0])) == $past(rd_data[3:0])));

    assert_ring_trailing_only_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_data[2]) |-> ($past(rd_data[6]) && !rd_data[6]));

    assert_carrier_change_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_data[3]) |-> (rd_data[7] != $past(rd_data[7])));

    assert_setready_change_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_data[1]) |-> (rd_data[5] != $past(rd_data[5])));

    assert_cts_change_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_data[0]) |-> (rd_data[4] != $past(rd_data[4])));

    assert_loop_map_R8: assert property (@(posedge clk) disable iff (rst)
        lb_en |=> (rd_data[7:4] == $past({lb_ctl[3], lb_ctl[2], lb_ctl[0], lb_ctl[1]})));
endmodule

bind modem_status_detect modem_status_detect_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .lb_ctl    (lb_ctl),
    .lb_en     (lb_en),
    .rd_strobe (rd_strobe),
    .rd_data   (rd_data),
    .irq       (irq),
    .evt_vec   (evt_vec)
);

// File: tb/modem_status_detect_test.sv
`timescale 1ns/1ps
module modem_status_detect_test;
    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] pins;       // {dcd, ri, dsr, cts}, active low
    logic [3:0] lb_ctl;
    logic       lb_en;
    logic       rd_strobe;
    logic [7:0] rd_data;
    logic       irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // bench model state
    logic [3:0] m_s1, m_s2, m_lvl, m_flg;

    always #2.5 clk = ~clk;

    modem_status_detect uut (
        .clk       (clk),
        .rst       (rst),
        .cts_pin_n (pins[0]),
        .dsr_pin_n (pins[1]),
        .ri_pin_n  (pins[2]),
        .dcd_pin_n (pins[3]),
        .lb_ctl    (lb_ctl),
        .lb_en     (lb_en),
        .rd_strobe (rd_strobe),
        .rd_data   (rd_data),
        .irq       (irq)
    );

    function automatic logic [3:0] exp_loop(input logic [3:0] c);
        return {c[3], c[2], c[0], c[1]};
    endfunction

    function automatic logic [3:0] exp_events(input logic [3:0] prev, input logic [3:0] cur);
        logic [3:0] e;
        e = prev ^ cur;
        e[2] = prev[2] & ~cur[2];
        return e;
    endfunction

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic check_model(input string tag);
        check8(tag, rd_data, {m_lvl, m_flg});
        check8("R7 irq", {7'd0, irq}, {7'd0, |m_flg});
    endtask

    // apply inputs after a negedge, advance one edge, check at the next negedge
    task automatic step(input logic [3:0] p, input logic [3:0] c, input logic lb,
                        input logic rd, input string tag);
        logic [3:0] asrt, evt;
        pins = p; lb_ctl = c; lb_en = lb; rd_strobe = rd;
        asrt  = lb ? exp_loop(c) : ~m_s2;
        evt   = exp_events(m_lvl, asrt);
        m_flg = (rd ? 4'h0 : m_flg) | evt;
        m_lvl = asrt;
        m_s2  = m_s1;
        m_s1  = p;
        @(posedge clk);
        @(negedge clk);
        check_model(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #400000;
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; pins = 4'hF; lb_ctl = 4'h0; lb_en = 1'b0; rd_strobe = 1'b0;
        m_s1 = 4'hF; m_s2 = 4'hF; m_lvl = 4'h0; m_flg = 4'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check8("R10 reset word", rd_data, 8'h00);
        check8("R10 reset irq", {7'd0, irq}, 8'h00);

        // clear-to-send pin falls: level and change flag after three edges
        for (int i = 0; i < 3; i++) step(4'hE, 4'h0, 1'b0, 1'b0, "R2");
        check8("R1 layout cts", rd_data, 8'h11);
        step(4'hE, 4'h0, 1'b0, 1'b1, "R5");
        check8("R5 read clears", rd_data, 8'h10);
        step(4'hE, 4'h0, 1'b0, 1'b0, "R5");
        check8("R5 stays clear", rd_data, 8'h10);

        // ring pin falls: no flag
        for (int i = 0; i < 3; i++) step(4'hA, 4'h0, 1'b0, 1'b0, "R4");
        check8("R4 leading edge ignored", rd_data, 8'h50);
        // ring pin rises: trailing-edge flag
        for (int i = 0; i < 3; i++) step(4'hE, 4'h0, 1'b0, 1'b0, "R4");
        check8("R4 trailing edge", rd_data, 8'h14);
        step(4'hE, 4'h0, 1'b0, 1'b1, "R5");
        check8("R5 read clears ring", rd_data, 8'h10);

        // set-ready change lands on the read edge
        step(4'hC, 4'h0, 1'b0, 1'b0, "R6");
        step(4'hC, 4'h0, 1'b0, 1'b0, "R6");
        step(4'hC, 4'h0, 1'b0, 1'b1, "R6");
        check8("R6 change kept over read", rd_data, 8'h32);
        step(4'hC, 4'h0, 1'b0, 1'b1, "R5");
        check8("R5 read after retain", rd_data, 8'h30);

        // loopback: only request-to-send set
        step(4'hC, 4'h2, 1'b1, 1'b0, "R8");
        check8("R8 rts to cts", rd_data, 8'h12);
        for (int i = 0; i < 4; i++) step(4'h0, 4'h2, 1'b1, 1'b0, "R9");
        check8("R9 pins isolated", rd_data, 8'h12);
        for (int i = 0; i < 3; i++) step(4'hF, 4'h2, 1'b1, 1'b0, "R9");
        check8("R9 pins isolated back", rd_data, 8'h12);
        step(4'hF, 4'hF, 1'b1, 1'b0, "R8");
        check8("R8 all controls", rd_data, 8'hFA);
        step(4'hF, 4'hB, 1'b1, 1'b1, "R8");
        check8("R8 out1 drop gives ring flag", rd_data, 8'hB4);
        step(4'hF, 4'hB, 1'b1, 1'b1, "R5");
        step(4'hF, 4'h0, 1'b0, 1'b1, "R2");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] p, c;
            logic lb, rd;
            p  = pins;
            for (int b = 0; b < 4; b++)
                if (($urandom % 6) == 0) p[b] = ~p[b];
            c  = lb_ctl;
            if (($urandom % 5) == 0) c = 4'($urandom);
            lb = lb_en;
            if (($urandom % 50) == 0) lb = ~lb;
            rd = (($urandom % 4) == 0);
            step(p, c, lb, rd, lb ? "R8 random" : "R3 random");
        end

        finish_run();
    end
endmodule